// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block works out the divider settings of a PLL for a requested output frequency. The frequency is given in kHz, and the PLL runs from a fixed reference clock that is set by a parameter. A request is one `start_i` cycle with the target frequency on `target_i`. The block first picks an output divider and an extra post-divider, so that the VCO lands inside its legal range. It then walks the reference divider upward one value at a time, finds the feedback divider closest to the VCO frequency for each value, and keeps the best candidate it has seen.

All divisions go through one shared serial divider, so a search takes some thousands of cycles. The end of every request is marked by a single-cycle `done_o` pulse. With that pulse come either the chosen reference divider, feedback divider, output divider and post-divider, or an error code with all four settings at zero. Arithmetic is unsigned and truncating.

Top module: `pll_div_search`

## Requirements
- R1: A request with a target of 0 produces `done_o` on the clock edge after the edge that accepts it, with `err_o` = 1 and every divider output 0.
- R2: The output divider starts as ceil(440000 / target). The post-divider is ceil(that / 16). The output divider is then recomputed as ceil(initial / post-divider), and any value above 1 is rounded up to the next even number.
- R3: The VCO frequency is target × output divider × post-divider. The request ends with `err_o` = 2 and zero divider outputs when that VCO lies below 440000 or above 2200000, or when the output divider exceeds 16.
- R4: Reference divider candidates run from 1 to 63 in rising order, each with comparison frequency REF_KHZ / NR. The walk stops at the first candidate whose comparison frequency is under 269. A candidate whose comparison frequency is over 2200000 is passed over.
- R5: For each candidate, NF = floor(VCO / comparison frequency), and the candidate is dropped when NF ≥ 4096. When the remainder is more than half the comparison frequency and NF+1 < 4096, NF is raised by one and the error becomes the comparison frequency minus the remainder. Otherwise the error is the remainder.
- R6: A candidate becomes the best only when its error is strictly below the best error so far, which starts at the VCO value. On a tie the lower NR stays. The walk ends as soon as the best error reaches 0.
- R7: When the best error is above 4000, the request ends with `err_o` = 3 and zero divider outputs. Otherwise it ends with `err_o` = 0 and the best NR, NF, output divider and post-divider.
- R8: Each accepted request gives exactly one `done_o` pulse, one cycle wide. The result outputs hold their values until the next result.
- R9: `start_i` is accepted only while the block is idle. A `start_i` during a search is ignored, and later changes of `target_i` do not affect the running request.
- R10: After reset `done_o` is 0, and `err_o` and all divider outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| target_i | input | FREQ_W | Requested output frequency in kHz |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 2 | 0 ok, 1 zero target, 2 no legal VCO, 3 tolerance miss |
| nr_o | output | NR_W | Chosen reference divider |
| nf_o | output | NF_W | Chosen feedback divider |
| no_o | output | NO_W | Chosen output divider |
| pdiv_o | output | PDIV_W | Chosen extra post-divider |

## Verification
A zero target is the only result with a fixed latency. It is due on the edge right after the accepting edge, and the bench samples `done_o` and `err_o` on the falling edge that follows.

Every other result arrives after a number of serial divisions that depends on the data. Each division takes the internal width plus one cycles, so the bench waits for the `done_o` pulse within a bound derived from 63 candidates at two divisions each. It then compares the values captured at that pulse with a behavioural model of the requirements. The model is run for three reference frequencies, so that the skip, early-stop and tolerance paths are reached.

After a pulse the bench watches a quiet window to confirm that the outputs hold and that no second pulse appears.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int VCO_MIN_KHZ  = 440000;
  localparam int VCO_MAX_KHZ  = 2200000;
  localparam int FREF_MIN_KHZ = 269;
  localparam int FREF_MAX_KHZ = 2200000;
  localparam int TOL_KHZ      = 4000;

  typedef enum logic [1:0] {
    PS_OK       = 2'd0,
    PS_ERR_ZERO = 2'd1,
    PS_ERR_VCO  = 2'd2,
    PS_ERR_TOL  = 2'd3
  } ps_err_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_NO0,
    S_NO1,
    S_REF,
    S_FREF,
    S_NF,
    S_NEXT,
    S_FIN
  } ps_state_e;

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int W = 27
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    trial, sub;
  logic          take;

  assign trial = {acc_q, quo_q[W-1]};
  assign sub   = trial - {1'b0, dvs_q};
  assign take  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        acc_q  <= '0;
        quo_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= take ? sub[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;
  assign rem_o  = acc_q;

  AST_DIV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (acc_q < dvs_q)); // R5
  AST_DIV_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R9

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int W    = 27,
  parameter int NF_W = 12
) (
  input  logic [W-1:0]    quot_i,
  input  logic [W-1:0]    rem_i,
  input  logic [W-1:0]    fref_i,
  input  logic [W-1:0]    best_i,
  output logic            ok_o,
  output logic            better_o,
  output logic [NF_W-1:0] nf_o,
  output logic [W-1:0]    diff_o
);
  localparam logic [W-1:0] NF_LIM = W'(1) << NF_W;

  logic [W-1:0] half, nf_w;
  logic         bump;

  always_comb begin
    half     = fref_i >> 1;
    bump     = ((quot_i + W'(1)) < NF_LIM) && (rem_i > half);
    nf_w     = bump ? quot_i + W'(1) : quot_i;
    diff_o   = bump ? fref_i - rem_i : rem_i;
    ok_o     = quot_i < NF_LIM;
    better_o = ok_o && (diff_o < best_i);
    nf_o     = nf_w[NF_W-1:0];
  end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int FREQ_W  = 24,
  parameter int REF_KHZ = 24000,
  parameter int NR_W    = 6,
  parameter int NF_W    = 12,
  parameter int NO_MAX  = 16,
  parameter int NO_W    = $clog2(NO_MAX + 1),
  parameter int PDIV_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] target_i,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic [NR_W-1:0]   nr_o,
  output logic [NF_W-1:0]   nf_o,
  output logic [NO_W-1:0]   no_o,
  output logic [PDIV_W-1:0] pdiv_o
);
  localparam int PROD_W = FREQ_W + 3;
  localparam int VW     = 3 * PROD_W;
  localparam int NR_MAX = (1 << NR_W) - 1;
  localparam int NO_SH  = $clog2(NO_MAX);

  ps_state_e   st_q;
  ps_err_e     err_q;
  logic [PROD_W-1:0] tgt_q, pd_q, no_q, vco_q, fref_q, best_q;
  logic [NR_W-1:0]   nr_q, bnr_q;
  logic [NF_W-1:0]   bnf_q;

  logic              done_q;
  logic [1:0]        err_out_q;
  logic [NR_W-1:0]   nr_out_q;
  logic [NF_W-1:0]   nf_out_q;
  logic [NO_W-1:0]   no_out_q;
  logic [PDIV_W-1:0] pd_out_q;

  logic              div_start, div_busy, div_done;
  logic [PROD_W-1:0] div_a, div_b, div_q, div_r;

  logic [PROD_W-1:0] pd_calc, no_rnd;
  logic [VW-1:0]     vco_full;
  logic              vco_bad, fref_low, fref_high;

  logic              cand_ok, cand_better;
  logic [NF_W-1:0]   cand_nf;
  logic [PROD_W-1:0] cand_diff;

  pll_seq_div #(.W(PROD_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_a),
    .divisor_i  (div_b),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_q),
    .rem_o      (div_r)
  );

  pll_cand_eval #(.W(PROD_W), .NF_W(NF_W)) u_cand (
    .quot_i   (div_q),
    .rem_i    (div_r),
    .fref_i   (fref_q),
    .best_i   (best_q),
    .ok_o     (cand_ok),
    .better_o (cand_better),
    .nf_o     (cand_nf),
    .diff_o   (cand_diff)
  );

  // post-divider and even-rounded output divider from divider results
  always_comb begin
    pd_calc   = (div_q + PROD_W'(NO_MAX - 1)) >> NO_SH;
    no_rnd    = (div_q > PROD_W'(1)) ? ((div_q + PROD_W'(1)) & ~PROD_W'(1)) : div_q;
    vco_full  = VW'(tgt_q) * VW'(no_rnd) * VW'(pd_q);
    vco_bad   = (vco_full < VW'(VCO_MIN_KHZ)) || (vco_full > VW'(VCO_MAX_KHZ)) ||
                (no_rnd > PROD_W'(NO_MAX));
    fref_low  = div_q < PROD_W'(FREF_MIN_KHZ);
    fref_high = div_q > PROD_W'(FREF_MAX_KHZ);
  end

  always_comb begin
    div_start = 1'b0;
    div_a     = '0;
    div_b     = '0;
    case (st_q)
      S_IDLE: if (start_i && target_i != '0) begin
        div_start = 1'b1;
        div_a     = PROD_W'(VCO_MIN_KHZ) + PROD_W'(target_i) - PROD_W'(1);
        div_b     = PROD_W'(target_i);
      end
      S_NO0: if (div_done) begin
        div_start = 1'b1;
        div_a     = div_q + pd_calc - PROD_W'(1);
        div_b     = pd_calc;
      end
      S_REF: begin
        div_start = 1'b1;
        div_a     = PROD_W'(REF_KHZ);
        div_b     = PROD_W'(nr_q);
      end
      S_FREF: if (div_done && !fref_low && !fref_high) begin
        div_start = 1'b1;
        div_a     = vco_q;
        div_b     = div_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      err_q     <= PS_OK;
      tgt_q     <= '0;
      pd_q      <= '0;
      no_q      <= '0;
      vco_q     <= '0;
      fref_q    <= '0;
      best_q    <= '0;
      nr_q      <= '0;
      bnr_q     <= '0;
      bnf_q     <= '0;
      done_q    <= 1'b0;
      err_out_q <= '0;
      nr_out_q  <= '0;
      nf_out_q  <= '0;
      no_out_q  <= '0;
      pd_out_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (target_i == '0) begin
            done_q    <= 1'b1;
            err_out_q <= PS_ERR_ZERO;
            nr_out_q  <= '0;
            nf_out_q  <= '0;
            no_out_q  <= '0;
            pd_out_q  <= '0;
          end else begin
            tgt_q <= PROD_W'(target_i);
            err_q <= PS_OK;
            st_q  <= S_NO0;
          end
        end
        S_NO0: if (div_done) begin
          pd_q <= pd_calc;
          st_q <= S_NO1;
        end
        S_NO1: if (div_done) begin
          no_q <= no_rnd;
          if (vco_bad) begin
            err_q <= PS_ERR_VCO;
            st_q  <= S_FIN;
          end else begin
            vco_q  <= vco_full[PROD_W-1:0];
            best_q <= vco_full[PROD_W-1:0];
            nr_q   <= NR_W'(1);
            bnr_q  <= '0;
            bnf_q  <= '0;
            st_q   <= S_REF;
          end
        end
        S_REF: st_q <= S_FREF;
        S_FREF: if (div_done) begin
          if (fref_low)       st_q <= S_FIN;
          else if (fref_high) st_q <= S_NEXT;
          else begin
            fref_q <= div_q;
            st_q   <= S_NF;
          end
        end
        S_NF: if (div_done) begin
          if (cand_better) begin
            best_q <= cand_diff;
            bnr_q  <= nr_q;
            bnf_q  <= cand_nf;
          end
          st_q <= S_NEXT;
        end
        S_NEXT: begin
          if (nr_q == NR_W'(NR_MAX) || best_q == '0) st_q <= S_FIN;
          else begin
            nr_q <= nr_q + NR_W'(1);
            st_q <= S_REF;
          end
        end
        S_FIN: begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
          if (err_q != PS_OK || best_q > PROD_W'(TOL_KHZ)) begin
            err_out_q <= (err_q != PS_OK) ? err_q : PS_ERR_TOL;
            nr_out_q  <= '0;
            nf_out_q  <= '0;
            no_out_q  <= '0;
            pd_out_q  <= '0;
          end else begin
            err_out_q <= PS_OK;
            nr_out_q  <= bnr_q;
            nf_out_q  <= bnf_q;
            no_out_q  <= no_q[NO_W-1:0];
            pd_out_q  <= pd_q[PDIV_W-1:0];
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_out_q;
  assign nr_o   = nr_out_q;
  assign nf_o   = nf_out_q;
  assign no_o   = no_out_q;
  assign pdiv_o = pd_out_q;

  AST_ZERO_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && start_i && target_i == '0) |=> (done_o && err_o == 2'd1)); // R1
  AST_NO_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 2'd0) |-> (no_o == NO_W'(1) || (!no_o[0] && no_o != '0 && no_o <= NO_W'(NO_MAX)))); // R2
  AST_ERR_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o != 2'd0) |-> (nr_o == '0 && nf_o == '0 && no_o == '0 && pdiv_o == '0)); // R7
  AST_NR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 2'd0) |-> (nr_o != '0)); // R4
  AST_BEST_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_REF || st_q == S_FREF || st_q == S_NF || st_q == S_NEXT) |=> (best_q <= $past(best_q))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

endmodule

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  localparam int FREQ_W = 24;
  localparam int NT     = 16;
  localparam longint REF_MAIN = 24000;
  localparam longint REF_HI   = 20000000;
  localparam longint REF_LO   = 10000;

  localparam longint TGT [NT] = '{0, 100, 1, 7, 25000, 30000, 27500, 150000,
                                  333333, 440000, 1234567, 2200000, 2200001,
                                  16000000, 1100000, 999999};
  localparam int EXP_ERR [NT] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 2, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FREQ_W-1:0] target = '0;

  always #10 clk = ~clk;

  logic d0, d1, d2;
  logic [1:0] e0, e1, e2;
  logic [5:0] r0, r1, r2;
  logic [11:0] f0, f1, f2;
  logic [4:0] o0, o1, o2;
  logic [14:0] p0, p1, p2;

  pll_div_search #(.FREQ_W(FREQ_W), .REF_KHZ(24000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_i(target),
    .done_o(d0), .err_o(e0), .nr_o(r0), .nf_o(f0), .no_o(o0), .pdiv_o(p0));
  pll_div_search #(.FREQ_W(FREQ_W), .REF_KHZ(20000000)) u_dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_i(target),
    .done_o(d1), .err_o(e1), .nr_o(r1), .nf_o(f1), .no_o(o1), .pdiv_o(p1));
  pll_div_search #(.FREQ_W(FREQ_W), .REF_KHZ(10000)) u_dut_lo (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_i(target),
    .done_o(d2), .err_o(e2), .nr_o(r2), .nf_o(f2), .no_o(o2), .pdiv_o(p2));

  int n_chk = 0;
  int n_fail = 0;
  int cnt0 = 0, cnt1 = 0, cnt2 = 0;
  logic [1:0] c0e, c1e, c2e;
  logic [5:0] c0r, c1r, c2r;
  logic [11:0] c0f, c1f, c2f;
  logic [4:0] c0o, c1o, c2o;
  logic [14:0] c0p, c1p, c2p;

  always @(negedge clk) begin
    if (rst_n && d0) begin cnt0 <= cnt0 + 1; c0e <= e0; c0r <= r0; c0f <= f0; c0o <= o0; c0p <= p0; end
    if (rst_n && d1) begin cnt1 <= cnt1 + 1; c1e <= e1; c1r <= r1; c1f <= f1; c1o <= o1; c1p <= p1; end
    if (rst_n && d2) begin cnt2 <= cnt2 + 1; c2e <= e2; c2r <= r2; c2f <= f2; c2o <= o2; c2p <= p2; end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void ref_model(input longint t, input longint refk, output int e,
                                    output longint nr, output longint nf,
                                    output longint no, output longint pd);
    longint n0, p, n1, vco, best, bnr, bnf;
    nr = 0; nf = 0; no = 0; pd = 0;
    if (t == 0) begin e = 1; return; end
    n0 = (440000 + t - 1) / t;
    p  = (n0 + 15) / 16;
    n1 = (n0 + p - 1) / p;
    if (n1 > 1) n1 = ((n1 + 1) / 2) * 2;
    vco = t * n1 * p;
    if (vco < 440000 || vco > 2200000 || n1 > 16) begin e = 2; return; end
    best = vco; bnr = 0; bnf = 0;
    for (longint r = 1; r < 64 && best != 0; r++) begin
      longint fr, q, d;
      fr = refk / r;
      if (fr < 269) break;
      if (fr > 2200000) continue;
      q = vco / fr;
      if (q >= 4096) continue;
      d = vco - q * fr;
      if (q + 1 < 4096 && d > fr / 2) begin q++; d = fr - d; end
      if (d < best) begin best = d; bnr = r; bnf = q; end
    end
    if (best > 4000) begin e = 3; return; end
    e = 0; nr = bnr; nf = bnf; no = n1; pd = p;
  endfunction

  task automatic cmp_one(input string tag, input longint t, input longint refk,
                         input longint ae, input longint ar, input longint af,
                         input longint ao, input longint ap);
    int e; longint nr, nf, no, pd;
    ref_model(t, refk, e, nr, nf, no, pd);
    chk(tag, $sformatf("err t=%0d ref=%0d", t, refk), ae, e);
    chk(tag, $sformatf("nr t=%0d ref=%0d", t, refk), ar, nr);
    chk(tag, $sformatf("nf t=%0d ref=%0d", t, refk), af, nf);
    chk(tag, $sformatf("no t=%0d ref=%0d", t, refk), ao, no);
    chk(tag, $sformatf("pdiv t=%0d ref=%0d", t, refk), ap, pd);
  endtask

  task automatic run_req(input longint t, input string tag);
    int b0, b1, b2, w;
    b0 = cnt0; b1 = cnt1; b2 = cnt2;
    @(negedge clk);
    target = FREQ_W'(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while ((cnt0 == b0 || cnt1 == b1 || cnt2 == b2) && w < 8000) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    chk(tag, $sformatf("done seen t=%0d", t), (cnt0 > b0 && cnt1 > b1 && cnt2 > b2) ? 1 : 0, 1);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    string tags [NT];
    int k;
    tags = '{"R1", "R2", "R2", "R2", "R2", "R2", "R2", "R5", "R5", "R6",
             "R5", "R6", "R3", "R3", "R4", "R5"};
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "done", d0, 0);
    chk("R10", "err", e0, 0);
    chk("R10", "nr|nf|no|pdiv", longint'(r0) + f0 + o0 + p0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: exact latency for a zero target
    target = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "done one edge after start", d0, 1);
    chk("R1", "err zero target", e0, 1);
    @(negedge clk);
    chk("R8", "done drops after one cycle", d0, 0);
    repeat (2) @(negedge clk);

    // table of requests, each checked on all three reference frequencies
    for (int i = 0; i < NT; i++) begin
      run_req(TGT[i], tags[i]);
      chk(tags[i], $sformatf("table err t=%0d", TGT[i]), c0e, EXP_ERR[i]);
      cmp_one(tags[i], TGT[i], REF_MAIN, c0e, c0r, c0f, c0o, c0p);
      cmp_one("R4", TGT[i], REF_HI, c1e, c1r, c1f, c1o, c1p);
      cmp_one("R4", TGT[i], REF_LO, c2e, c2r, c2f, c2o, c2p);
    end

    // R2: hand-computed settings
    run_req(100, "R2");
    chk("R2", "nr t=100", c0r, 3);
    chk("R2", "nf t=100", c0f, 55);
    chk("R2", "no t=100", c0o, 16);
    chk("R2", "pdiv t=100", c0p, 275);
    run_req(2200000, "R6");
    chk("R6", "nr t=2200000", c0r, 3);
    chk("R6", "nf t=2200000", c0f, 275);
    chk("R6", "no t=2200000", c0o, 1);

    // R7: tolerance miss on the high reference instance
    run_req(1100000, "R7");
    chk("R7", "err tolerance miss", c1e, 3);
    chk("R7", "zeroed nr|nf", longint'(c1r) + c1f, 0);

    // R9: start and target changes during a search are ignored
    k = cnt0;
    @(negedge clk);
    target = FREQ_W'(1234567);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    target = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    target = FREQ_W'(50000);
    for (int w = 0; w < 8000 && cnt0 == k; w++) @(negedge clk);
    @(negedge clk);
    cmp_one("R9", 1234567, REF_MAIN, c0e, c0r, c0f, c0o, c0p);
    repeat (300) @(negedge clk);
    // R8: one pulse per request, outputs held
    chk("R8", "done count", cnt0 - k, 1);
    chk("R8", "held nr", r0, c0r);
    chk("R8", "held nf", f0, c0f);
    chk("R8", "held pdiv", p0, c0p);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule